// File: doc/BRIEF.md
# Physically Addressed Data Cache with Per-Access Write Policy

This block is an 8 KB data cache that sits between a processor's load/store path and the memory system. Physical addresses index and tag it. Every request carries a two-bit page mode, so one cache holds write-through and copyback data side by side. Accesses to non-cacheable pages bypass the cache. Storage is four ways of 16-byte lines in 128 sets. A pseudo-LRU tree for each set chooses the line to replace.

The CPU raises `req_valid` with the address, byte enables, write data and mode. It holds them until `cpu_done` pulses for one cycle, and for a read `cpu_rdata` carries the result in that cycle. Towards memory the block raises `mem_req` with an operation code: line fill, line writeback, single-word write or single-word read. It holds every request field steady until `mem_ready` is sampled high.

The controller has seven states: IDLE, LOOKUP, EVICT, FILL, WORD_WR, WORD_RD and RESPOND.
- IDLE goes to LOOKUP when it captures a request.
- From LOOKUP:
  - a non-cacheable access goes to WORD_WR or WORD_RD;
  - a hit goes to RESPOND, or to WORD_WR for a write-through write;
  - a write-through write miss goes to WORD_WR;
  - any other miss goes to EVICT when the victim is dirty, and to FILL otherwise.
- EVICT goes to FILL on `mem_ready`.
- FILL, WORD_WR and WORD_RD go to RESPOND on `mem_ready`.
- RESPOND always returns to IDLE.

Top module: `dcache_pp`

## Requirements
- R1: After reset, `cpu_done` and `mem_req` are low and every line is invalid, so the first cacheable read of any address issues a fill.
- R2: For a line operation, `mem_addr` is the line base address. Bits [3:2] select the word in the line, bits [10:4] the set and bits [31:11] the tag.
- R3: A mode of 2'b10 or 2'b11 is non-cacheable. A read issues one word read (op 3) and returns memory data, even if the line is cached. A write issues one word write (op 2). Neither allocates a line.
- R4: A cacheable read miss allocates a line through a fill (op 0). Later reads in that line hit with no memory request.
- R5: A write hit on a copyback page (mode 2'b01) updates only the cache and marks the line dirty. It issues no memory request.
- R6: A write hit on a write-through page (mode 2'b00) updates the cached word and also issues one word write (op 2) with the request's byte enables.
- R7: A write miss on a write-through page issues one word write and no fill. A later read of that line misses.
- R8: A write miss on a copyback page fills the line first. It then merges the write data and marks the line dirty, with no word write.
- R9: A dirty victim is written back in full (op 1, at the victim's own line address) immediately before the fill that replaces it.
- R10: Replacement takes the lowest-numbered invalid way first. Otherwise it takes the way named by the set's pseudo-LRU tree, which is updated on every hit and every fill.
- R11: `mem_req` holds `mem_op` and `mem_addr` stable until `mem_ready`. `cpu_done` is a single-cycle pulse.
- R12: A write changes only the bytes whose byte enable is set. Bit b of the byte enable maps to bits [8b+7:8b] of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request present, held until `cpu_done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_mode | input | 2 | Page mode: 00 write-through, 01 copyback, 1x non-cacheable |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request |
| mem_op | output | 2 | 0 fill, 1 writeback, 2 word write, 3 word read |
| mem_addr | output | 32 | Line base for ops 0 and 1, byte address for ops 2 and 3 |
| mem_be | output | 4 | Byte enables for word write |
| mem_wdata | output | 32 | Word write data |
| mem_wline | output | 128 | Line data for writeback |
| mem_ready | input | 1 | Memory completes the current request |
| mem_rline | input | 128 | Fill data; for a word read, data in bits [31:0] |

## Verification
Eviction of a dirty victim and the fill that replaces it are serviced back to back. The writeback's `mem_ready` cycle is followed at once by the fill request. The bench provokes this by filling all four ways of one set and dirtying the way that the tree will pick. It reorders the tree with hits and then reads a fifth tag. It then checks the two most recent memory operations, the writeback address and the memory image of the written word. A second case in the same cycle is a write-through write hit. There the cache line is updated in LOOKUP while the word write is issued; the bench checks both the memory image and a hit read-back with no memory traffic.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        OP_FILL = 2'd0,
        OP_WB   = 2'd1,
        OP_WWR  = 2'd2,
        OP_WRD  = 2'd3
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WORD_WR,
        ST_WORD_RD,
        ST_RESPOND
    } state_e;

    localparam logic [1:0] MODE_WT = 2'b00;
    localparam logic [1:0] MODE_CB = 2'b01;

endpackage

// File: rtl/dcache_plru.sv
module dcache_plru #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree_in,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAYS-2:0]  tree_out,
    output logic [WAY_W-1:0] victim
);
    // Tree node n has children 2n+1 (left) and 2n+2 (right); a node bit of 1 points right.
    always_comb begin
        int node;
        logic b;
        node   = 0;
        victim = '0;
        for (int l = 0; l < WAY_W; l++) begin
            b = tree_in[node];
            victim[WAY_W-1-l] = b;
            node = 2 * node + 1 + int'(b);
        end
        tree_out = tree_in;
        node     = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b = touch_way[WAY_W-1-l];
            tree_out[node] = ~b;
            node = 2 * node + 1 + int'(b);
        end
    end
endmodule

// File: rtl/dcache_store.sv
module dcache_store #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 21,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              idx,
    input  logic [TAG_W-1:0]              cmp_tag,
    output logic [WAYS-1:0]               hit_vec,
    output logic [WAYS-1:0][TAG_W-1:0]    way_tag,
    output logic [WAYS-1:0]               way_valid,
    output logic [WAYS-1:0]               way_dirty,
    output logic [WAYS-1:0][LINE_W-1:0]   way_line,
    output logic [WAYS-2:0]               tree,
    input  logic                          line_we,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic                          wr_dirty,
    input  logic [LINE_W-1:0]             wr_line,
    input  logic                          tree_we,
    input  logic [WAYS-2:0]               tree_new
);
    logic [LINE_W-1:0] data_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [WAYS-2:0]   tree_q  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                tree_q[s]  <= '0;
            end
        end else begin
            if (line_we) begin
                valid_q[idx][wr_way] <= 1'b1;
                dirty_q[idx][wr_way] <= wr_dirty;
            end
            if (tree_we) tree_q[idx] <= tree_new;
        end
    end

    always_ff @(posedge clk) begin
        if (line_we) begin
            data_q[idx][wr_way] <= wr_line;
            tag_q[idx][wr_way]  <= wr_tag;
        end
    end

    assign way_valid = valid_q[idx];
    assign way_dirty = dirty_q[idx];
    assign tree      = tree_q[idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_tag[w]  = tag_q[idx][w];
        assign way_line[w] = data_q[idx][w];
        assign hit_vec[w]  = valid_q[idx][w] && (tag_q[idx][w] == cmp_tag);
    end
endmodule

// File: rtl/dcache_pp.sv
module dcache_pp #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int CAP_BYTES  = 8192,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int BE_W   = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [1:0]        req_mode,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [LINE_W-1:0] mem_wline,
    input  logic              mem_ready,
    input  logic [LINE_W-1:0] mem_rline
);
    import dcache_pkg::*;

    localparam int SETS   = CAP_BYTES / (LINE_BYTES * WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BOFF_W = $clog2(BE_W);
    localparam int WSEL_W = OFF_W - BOFF_W;
    localparam int WAY_W  = $clog2(WAYS);

    state_e              st_q, st_d;
    logic                rq_we;
    logic [ADDR_W-1:0]   rq_addr;
    logic [BE_W-1:0]     rq_be;
    logic [WORD_W-1:0]   rq_wdata;
    logic [1:0]          rq_mode;
    logic [WAY_W-1:0]    vic_q;
    logic [WORD_W-1:0]   rdata_q;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tag;
    logic [WSEL_W-1:0]   wsel;
    logic [WAYS-1:0]     hit_vec;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0]     way_valid, way_dirty;
    logic [WAYS-1:0][LINE_W-1:0] way_line;
    logic [WAYS-2:0]     tree, tree_new;
    logic [WAY_W-1:0]    hit_way, inv_way, plru_vic, victim, touch_way;
    logic                hit, inv_found, is_nc, is_cb, wt_write;
    logic                line_we, wr_dirty, tree_we;
    logic [WAY_W-1:0]    wr_way;
    logic [LINE_W-1:0]   wr_line;

    function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] l,
                                                     input logic [WSEL_W-1:0] ws,
                                                     input logic [BE_W-1:0]   be,
                                                     input logic [WORD_W-1:0] d);
        logic [LINE_W-1:0] r;
        r = l;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) r[int'(ws) * WORD_W + b * 8 +: 8] = d[b * 8 +: 8];
        return r;
    endfunction

    assign idx      = rq_addr[OFF_W +: IDX_W];
    assign tag      = rq_addr[ADDR_W-1 -: TAG_W];
    assign wsel     = rq_addr[BOFF_W +: WSEL_W];
    assign is_nc    = rq_mode[1];
    assign is_cb    = (rq_mode == MODE_CB);
    assign wt_write = rq_we && !is_cb;
    assign hit      = |hit_vec;

    always_comb begin
        hit_way   = '0;
        inv_way   = '0;
        inv_found = 1'b0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!way_valid[w]) begin
                inv_way   = WAY_W'(w);
                inv_found = 1'b1;
            end
    end
    assign victim    = inv_found ? inv_way : plru_vic;
    assign touch_way = (st_q == ST_FILL) ? vic_q : hit_way;

    dcache_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx(idx), .cmp_tag(tag), .hit_vec(hit_vec),
        .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty),
        .way_line(way_line), .tree(tree), .line_we(line_we), .wr_way(wr_way),
        .wr_tag(tag), .wr_dirty(wr_dirty), .wr_line(wr_line),
        .tree_we(tree_we), .tree_new(tree_new)
    );

    dcache_plru #(.WAYS(WAYS)) u_plru (
        .tree_in(tree), .touch_way(touch_way), .tree_out(tree_new), .victim(plru_vic)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (is_nc)         st_d = rq_we ? ST_WORD_WR : ST_WORD_RD;
                else if (hit)      st_d = wt_write ? ST_WORD_WR : ST_RESPOND;
                else if (wt_write) st_d = ST_WORD_WR;
                else if (way_valid[victim] && way_dirty[victim]) st_d = ST_EVICT;
                else               st_d = ST_FILL;
            end
            ST_EVICT:   if (mem_ready) st_d = ST_FILL;
            ST_FILL,
            ST_WORD_WR,
            ST_WORD_RD: if (mem_ready) st_d = ST_RESPOND;
            ST_RESPOND: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Outputs and array write controls
    always_comb begin
        cpu_done  = (st_q == ST_RESPOND);
        mem_req   = 1'b0;
        mem_op    = OP_FILL;
        mem_addr  = {tag, idx, {OFF_W{1'b0}}};
        mem_be    = '1;
        mem_wdata = rq_wdata;
        mem_wline = '0;
        line_we   = 1'b0;
        wr_way    = vic_q;
        wr_dirty  = 1'b0;
        wr_line   = mem_rline;
        tree_we   = 1'b0;
        unique case (st_q)
            ST_LOOKUP: if (!is_nc && hit) begin
                tree_we = 1'b1;
                if (rq_we) begin
                    line_we  = 1'b1;
                    wr_way   = hit_way;
                    wr_dirty = way_dirty[hit_way] | is_cb;
                    wr_line  = merge_word(way_line[hit_way], wsel, rq_be, rq_wdata);
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_op    = OP_WB;
                mem_addr  = {way_tag[vic_q], idx, {OFF_W{1'b0}}};
                mem_wline = way_line[vic_q];
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    line_we  = 1'b1;
                    tree_we  = 1'b1;
                    wr_dirty = rq_we;
                    wr_line  = rq_we ? merge_word(mem_rline, wsel, rq_be, rq_wdata) : mem_rline;
                end
            end
            ST_WORD_WR: begin
                mem_req  = 1'b1;
                mem_op   = OP_WWR;
                mem_addr = rq_addr;
                mem_be   = rq_be;
            end
            ST_WORD_RD: begin
                mem_req  = 1'b1;
                mem_op   = OP_WRD;
                mem_addr = rq_addr;
            end
            default: ;
        endcase
    end

    // Request capture, victim and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_addr  <= '0;
            rq_be    <= '0;
            rq_wdata <= '0;
            rq_mode  <= '0;
            vic_q    <= '0;
            rdata_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                rq_we    <= req_we;
                rq_addr  <= req_addr;
                rq_be    <= req_be;
                rq_wdata <= req_wdata;
                rq_mode  <= req_mode;
            end
            if (st_q == ST_LOOKUP) begin
                vic_q <= victim;
                if (hit) rdata_q <= way_line[hit_way][int'(wsel) * WORD_W +: WORD_W];
            end
            if (st_q == ST_FILL && mem_ready)
                rdata_q <= mem_rline[int'(wsel) * WORD_W +: WORD_W];
            if (st_q == ST_WORD_RD && mem_ready)
                rdata_q <= mem_rline[WORD_W-1:0];
        end
    end

    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dcache_pp_chk.sv
module dcache_pp_chk #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_done,
    input logic                 mem_req,
    input logic                 mem_ready,
    input logic [1:0]           mem_op,
    input logic [ADDR_W-1:0]    mem_addr,
    input dcache_pkg::state_e   st,
    input logic                 rq_we,
    input logic [1:0]           rq_mode,
    input logic                 hit,
    input logic [WAYS-1:0]      hit_vec
);
    import dcache_pkg::*;

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_op));

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_op == 2'(OP_WB) && mem_ready |=> mem_req && mem_op == 2'(OP_FILL));

    p_cb_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_LOOKUP && rq_we && rq_mode == MODE_CB && hit |=> !mem_req && cpu_done);

    p_wt_miss_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_LOOKUP && rq_we && rq_mode == MODE_WT && !hit
        |=> mem_req && mem_op == 2'(OP_WWR));

    p_unique_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind dcache_pp dcache_pp_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_op(mem_op), .mem_addr(mem_addr), .st(st_q),
    .rq_we(rq_we), .rq_mode(rq_mode), .hit(hit), .hit_vec(hit_vec)
);

// File: tb/dcache_pp_tb.sv
module dcache_pp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [1:0]  req_mode = '0;
    logic cpu_done, mem_req, mem_ready = 1'b0;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [1:0]  mem_op;
    logic [3:0]  mem_be;
    logic [127:0] mem_wline, mem_rline = '0;

    int n_chk = 0, n_fail = 0;
    int n_fill = 0, n_wb = 0, n_wwr = 0, n_wrd = 0;
    logic [31:0] last_fill_addr = '0, last_wb_addr = '0;
    logic [7:0]  op_seq = '0;
    bit pulse_ok;
    logic [31:0] mm [int unsigned];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dcache_pp u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_mode(req_mode),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_op(mem_op),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_wline(mem_wline),
        .mem_ready(mem_ready), .mem_rline(mem_rline)
    );

    function automatic logic [31:0] dflt(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a);
        int unsigned k = a >> 2;
        return mm.exists(k) ? mm[k] : dflt(a);
    endfunction

    function automatic int ops();
        return n_fill + n_wb + n_wwr + n_wrd;
    endfunction

    // Memory model: answers each request after LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (mem_req) begin
                repeat (LAT) @(negedge clk);
                op_seq = {op_seq[5:0], mem_op};
                case (mem_op)
                    2'd0: begin
                        n_fill++;
                        last_fill_addr = mem_addr;
                        for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = mrd(mem_addr + 32'(w*4));
                    end
                    2'd1: begin
                        n_wb++;
                        last_wb_addr = mem_addr;
                        for (int w = 0; w < 4; w++) mm[(mem_addr + 32'(w*4)) >> 2] = mem_wline[w*32 +: 32];
                    end
                    2'd2: begin
                        logic [31:0] v;
                        n_wwr++;
                        v = mrd(mem_addr);
                        for (int b = 0; b < 4; b++) if (mem_be[b]) v[b*8 +: 8] = mem_wdata[b*8 +: 8];
                        mm[mem_addr >> 2] = v;
                    end
                    default: begin
                        n_wrd++;
                        mem_rline = {96'd0, mrd(mem_addr)};
                    end
                endcase
                mem_ready = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input logic [1:0] mode, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = wd; req_mode = mode;
        do @(negedge clk); while (!cpu_done);
        rd = cpu_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        pulse_ok = !cpu_done;
    endtask

    localparam logic [31:0] A = 32'h0000_0810, B = 32'h0000_0820, C = 32'h0000_0830;
    localparam logic [31:0] D = 32'h0000_0840, E = 32'h0000_0860;

    function automatic logic [31:0] tk(input int k);
        return (32'(k) << 11) | (32'd5 << 4);
    endfunction

    task automatic t_reset();
        check(cpu_done == 1'b0, "R1 done low", 32'(cpu_done), 0);
        check(mem_req == 1'b0, "R1 req low", 32'(mem_req), 0);
    endtask

    task automatic t_read_miss();
        logic [31:0] rd; int o;
        o = n_fill;
        access(0, A, 4'hF, 0, 2'b00, rd);
        check(rd == dflt(A), "R4 miss data", rd, dflt(A));
        check(n_fill == o + 1, "R1 first read fills", 32'(n_fill - o), 1);
        check(last_fill_addr == A, "R2 fill line address", last_fill_addr, A);
        o = ops();
        access(0, A + 8, 4'hF, 0, 2'b00, rd);
        check(rd == dflt(A + 8), "R4 hit data", rd, dflt(A + 8));
        check(ops() == o, "R4 hit no mem", 32'(ops() - o), 0);
        check(pulse_ok, "R11 done one cycle", 0, 1);
    endtask

    task automatic t_cb_hit();
        logic [31:0] rd, ex; int o;
        o = ops();
        access(1, A + 4, 4'b0011, 32'h1234_ABCD, 2'b01, rd);
        check(ops() == o, "R5 cb hit no mem", 32'(ops() - o), 0);
        check(mrd(A + 4) == dflt(A + 4), "R5 memory untouched", mrd(A + 4), dflt(A + 4));
        ex = {dflt(A + 4)[31:16], 16'hABCD};
        access(0, A + 4, 4'hF, 0, 2'b01, rd);
        check(rd == ex, "R12 byte merge", rd, ex);
    endtask

    task automatic t_wt_hit();
        logic [31:0] rd; int of, ow, o;
        access(0, B, 4'hF, 0, 2'b00, rd);
        of = n_fill; ow = n_wwr;
        access(1, B, 4'hF, 32'hCAFE_0001, 2'b00, rd);
        check(n_wwr == ow + 1 && n_fill == of, "R6 one word write", 32'(n_wwr - ow), 1);
        check(mrd(B) == 32'hCAFE_0001, "R6 memory updated", mrd(B), 32'hCAFE_0001);
        o = ops();
        access(0, B, 4'hF, 0, 2'b00, rd);
        check(rd == 32'hCAFE_0001 && ops() == o, "R6 cache updated", rd, 32'hCAFE_0001);
    endtask

    task automatic t_wt_miss();
        logic [31:0] rd, ex; int of, ow;
        of = n_fill; ow = n_wwr;
        ex = {16'hBEEF, dflt(C)[15:0]};
        access(1, C, 4'b1100, 32'hBEEF_0000, 2'b00, rd);
        check(n_wwr == ow + 1 && n_fill == of, "R7 direct write no fill", 32'(n_fill - of), 0);
        access(0, C, 4'hF, 0, 2'b00, rd);
        check(n_fill == of + 1, "R7 not allocated", 32'(n_fill - of), 1);
        check(rd == ex, "R7 read data", rd, ex);
    endtask

    task automatic t_nc();
        logic [31:0] rd; int of, ow, orr;
        of = n_fill; orr = n_wrd;
        access(0, D, 4'hF, 0, 2'b10, rd);
        check(n_wrd == orr + 1 && n_fill == of && rd == dflt(D), "R3 nc read", rd, dflt(D));
        ow = n_wwr;
        access(1, D, 4'hF, 32'h0BAD_F00D, 2'b11, rd);
        check(n_wwr == ow + 1 && n_fill == of, "R3 nc write", 32'(n_wwr - ow), 1);
        access(0, D, 4'hF, 0, 2'b10, rd);
        check(rd == 32'h0BAD_F00D && n_fill == of, "R3 nc no allocate", rd, 32'h0BAD_F00D);
        access(0, A + 4, 4'hF, 0, 2'b11, rd);
        check(rd == dflt(A + 4), "R3 bypass cached line", rd, dflt(A + 4));
    endtask

    task automatic t_cb_miss();
        logic [31:0] rd, ex; int of, ow, o;
        of = n_fill; ow = n_wwr;
        access(1, E + 12, 4'b1000, 32'h7700_0000, 2'b01, rd);
        check(n_fill == of + 1 && n_wwr == ow, "R8 fill then merge", 32'(n_fill - of), 1);
        ex = {8'h77, dflt(E + 12)[23:0]};
        o = ops();
        access(0, E + 12, 4'hF, 0, 2'b01, rd);
        check(rd == ex && ops() == o, "R8 merged hit", rd, ex);
        check(mrd(E + 12) == dflt(E + 12), "R8 no memory write", mrd(E + 12), dflt(E + 12));
    endtask

    task automatic t_evict();
        logic [31:0] rd; int of, ow, o;
        of = n_fill;
        for (int k = 1; k <= 4; k++) access(0, tk(k), 4'hF, 0, 2'b01, rd);
        check(n_fill == of + 4, "R10 invalid ways used", 32'(n_fill - of), 4);
        access(1, tk(1), 4'hF, 32'h1111_1111, 2'b01, rd);
        access(0, tk(2), 4'hF, 0, 2'b01, rd);
        access(0, tk(4), 4'hF, 0, 2'b01, rd);
        ow = n_wb;
        access(0, tk(5), 4'hF, 0, 2'b01, rd);
        check(n_wb == ow + 1, "R9 dirty victim written back", 32'(n_wb - ow), 1);
        check(last_wb_addr == tk(1), "R9 writeback address", last_wb_addr, tk(1));
        check(mrd(tk(1)) == 32'h1111_1111, "R9 writeback data", mrd(tk(1)), 32'h1111_1111);
        check(op_seq[3:0] == 4'b0100, "R9 writeback before fill", 32'(op_seq[3:0]), 32'h4);
        check(rd == dflt(tk(5)), "R9 new line data", rd, dflt(tk(5)));
        o = ops();
        access(0, tk(2), 4'hF, 0, 2'b01, rd);
        check(ops() == o, "R10 recent way kept", 32'(ops() - o), 0);
        of = n_fill; ow = n_wb;
        access(0, tk(1), 4'hF, 0, 2'b01, rd);
        check(n_fill == of + 1 && n_wb == ow && rd == 32'h1111_1111, "R9 clean victim refetch", rd, 32'h1111_1111);
        o = ops();
        access(0, tk(4), 4'hF, 0, 2'b01, rd);
        check(ops() == o, "R10 way3 kept", 32'(ops() - o), 0);
        of = n_fill;
        access(0, tk(3), 4'hF, 0, 2'b01, rd);
        check(n_fill == of + 1, "R10 plru evicted way2", 32'(n_fill - of), 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read_miss();
        t_cb_hit();
        t_wt_hit();
        t_wt_miss();
        t_nc();
        t_cb_miss();
        t_evict();
        summary();
        $finish;
    end
endmodule